// File: doc/BRIEF.md
# Transmit Packet FIFO with Resynchronising Reset

This block buffers packet or cell words on the transmit path between an address-polled system-side write port and a line-side stream. The system side first selects the port by presenting its address with a select strobe, then writes 32-bit words, each tagged with start and end markers. The line side pulls the stored words, in order, through a valid/ready stream that carries the same markers. A space indication tells the system side when the port can take at least a set number of further words.

A software-visible hold bit, set on device reset, governs the buffer. While it is set the buffer is emptied, any transfer in progress is cut off, the port selection is dropped, all input words are discarded and space is reported as absent. When the bit is cleared the storage is modelled as waking from power-down for a fixed number of cycles. After that, words are still discarded until one flagged as start-of-packet arrives, so that stored data always begins on a packet boundary. The port has to be selected again before any write counts. A write that finds the buffer full is dropped and sets a sticky overflow flag.

Top module: `txpkt_fifo`

## Requirements
- R1: After device reset the hold bit reads 1 (`ctl_hold` high), `space_ok` is 0 and `rd_valid` is 0.
- R2: While the hold bit is 1, writes are discarded: `space_ok` stays 0 and nothing written in that time ever appears on the read side.
- R3: A control write of 0 to the hold bit starts a wake interval; `space_ok` stays 0 for PWR_CYC cycles after that write and rises on the PWR_CYC-th cycle after it.
- R4: After the wake interval, words are dropped until a word with `wr_sop`=1 is written; that word and the ones after it are stored.
- R5: The read side presents stored words in write order with their start and end flags; while `rd_valid`=1 and `rd_ready`=0, the word and flags are held unchanged.
- R6: A write counts only while the port is selected; a select strobe with `sel_addr`=PORT_ADDR selects the port and one with any other address deselects it.
- R7: Setting the hold bit clears the selection; after release, writes are ignored until a new select strobe with the port address.
- R8: Setting the hold bit empties the buffer: on the next cycle `rd_valid` is 0 and none of the words held before reappear afterwards.
- R9: `space_ok` is 1 only when the number of free entries in the storage is at least SPACE_MIN (the word held on the read output not counted as stored).
- R10: A write that finds the storage full (DEPTH words, plus one on the read output) is dropped and sets `ovf`; `ovf_clr`=1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high device reset |
| cfg_wr | input | 1 | Control write strobe for the hold bit |
| cfg_hold | input | 1 | Value written to the hold bit |
| ovf_clr | input | 1 | Write-1-to-clear for the overflow flag |
| ctl_hold | output | 1 | Current hold bit value |
| ovf | output | 1 | Sticky overflow flag |
| sel_vld | input | 1 | Port select strobe |
| sel_addr | input | ADDR_W | Address presented with the select strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write word |
| wr_sop | input | 1 | Word starts a packet |
| wr_eop | input | 1 | Word ends a packet |
| space_ok | output | 1 | Port can take SPACE_MIN more words |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Line side accepts the read word |
| rd_data | output | DATA_W | Read word |
| rd_sop | output | 1 | Read word starts a packet |
| rd_eop | output | 1 | Read word ends a packet |

## Verification
A stuck hold or wake state shows as `space_ok` staying low, or rising one cycle early or late, against a count started at the control write. A bad hunt state lets pre-packet junk words out, or loses the first packet, visible on the first word drained. Pointer or count errors show as words out of order, a wrong space threshold edge, or overflow raised one write early or late, all seen within a few cycles of the writes that cause them.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_WAKE = 2'd1,
    ST_HUNT = 2'd2,
    ST_RUN  = 2'd3
  } txf_state_e;

  localparam int FLAG_W = 2;
endpackage

// File: rtl/txf_mem.sv
module txf_mem #(
  parameter int WORD_W = 34,
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import txf_pkg::*;
#(
  parameter int PWR_CYC = 16,
  localparam int WC_W   = (PWR_CYC > 1) ? $clog2(PWR_CYC) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic       cfg_hold,
  input  logic       sop_seen,
  output txf_state_e st_q,
  output txf_state_e st_nx
);
  logic [WC_W-1:0] wc_q, wc_nx;

  always_comb begin
    st_nx = st_q;
    wc_nx = wc_q;
    if (cfg_wr && cfg_hold) begin
      st_nx = ST_HOLD;
    end else begin
      case (st_q)
        ST_HOLD: if (cfg_wr && !cfg_hold) begin
          st_nx = ST_WAKE;
          wc_nx = '0;
        end
        ST_WAKE: if (wc_q == WC_W'(PWR_CYC - 1)) st_nx = ST_HUNT;
                 else wc_nx = wc_q + 1'b1;
        ST_HUNT: if (sop_seen) st_nx = ST_RUN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_HOLD;
      wc_q <= '0;
    end else begin
      st_q <= st_nx;
      wc_q <= wc_nx;
    end
  end

  AST_WAKE_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAKE) |-> (wc_q <= WC_W'(PWR_CYC - 1))); // R3
  AST_HUNT_AFTER_WAKE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HUNT && $past(st_q) != ST_HUNT) |-> ($past(st_q) == ST_WAKE)); // R3
  AST_RUN_NEEDS_SOP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && $past(st_q) == ST_HUNT) |-> $past(sop_seen)); // R4
endmodule

// File: rtl/txpkt_fifo.sv
module txpkt_fifo
  import txf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16,
  parameter int SPACE_MIN = 8,
  parameter int PWR_CYC   = 16,
  parameter int ADDR_W    = 5,
  parameter int PORT_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_hold,
  input  logic              ovf_clr,
  output logic              ctl_hold,
  output logic              ovf,
  input  logic              sel_vld,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sop,
  input  logic              wr_eop,
  output logic              space_ok,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sop,
  output logic              rd_eop
);
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int WORD_W = DATA_W + FLAG_W;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] SPACE_C = CNT_W'(SPACE_MIN);

  txf_state_e st_q, st_nx;
  logic              selected_q;
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CNT_W-1:0]  count_q, count_nx;
  logic              hold_req, live, full;
  logic              store_ok, wr_try, push, pop, sop_seen;
  logic [WORD_W-1:0] mem_rdata;

  assign hold_req = cfg_wr && cfg_hold;
  assign live     = (st_q == ST_HUNT) || (st_q == ST_RUN);
  assign full     = (count_q == DEPTH_C);
  assign store_ok = (st_q == ST_RUN) || (st_q == ST_HUNT && wr_sop);
  assign wr_try   = wr_en && selected_q && store_ok && !hold_req;
  assign push     = wr_try && !full;
  assign pop      = live && !hold_req && (count_q != '0) && (!rd_valid || rd_ready);
  assign sop_seen = wr_en && selected_q && wr_sop;

  txf_ctrl #(.PWR_CYC(PWR_CYC)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_hold (cfg_hold),
    .sop_seen (sop_seen),
    .st_q     (st_q),
    .st_nx    (st_nx)
  );

  txf_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (push),
    .waddr (wptr_q),
    .wdata ({wr_sop, wr_eop, wr_data}),
    .re    (pop),
    .raddr (rptr_q),
    .rdata (mem_rdata)
  );

  assign ctl_hold = (st_q == ST_HOLD);
  assign {rd_sop, rd_eop, rd_data} = mem_rdata;

  always_comb begin
    if (st_nx == ST_HOLD) count_nx = '0;
    else count_nx = count_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      selected_q <= 1'b0;
      wptr_q     <= '0;
      rptr_q     <= '0;
      count_q    <= '0;
      rd_valid   <= 1'b0;
      space_ok   <= 1'b0;
      ovf        <= 1'b0;
    end else begin
      count_q  <= count_nx;
      space_ok <= ((st_nx == ST_HUNT) || (st_nx == ST_RUN)) &&
                  ((DEPTH_C - count_nx) >= SPACE_C);
      if (st_nx == ST_HOLD) begin
        selected_q <= 1'b0;
        wptr_q     <= '0;
        rptr_q     <= '0;
        rd_valid   <= 1'b0;
      end else begin
        if (sel_vld) selected_q <= (sel_addr == ADDR_W'(PORT_ADDR));
        if (push) wptr_q <= wptr_q + 1'b1;
        if (pop) begin
          rptr_q   <= rptr_q + 1'b1;
          rd_valid <= 1'b1;
        end else if (rd_ready) begin
          rd_valid <= 1'b0;
        end
      end
      if (ovf_clr) ovf <= 1'b0;
      else if (wr_try && full) ovf <= 1'b1;
    end
  end

  AST_HOLD_NO_SPACE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD || st_q == ST_WAKE) |-> !space_ok); // R2
  AST_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD) |-> !rd_valid); // R8
  AST_HOLD_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD) |-> (count_q == '0)); // R8
  AST_HOLD_UNSELECT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD) |-> !selected_q); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count_q <= DEPTH_C); // R10
  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready && !hold_req) |=> (rd_valid && $stable(mem_rdata))); // R5
  AST_SPACE_THRESH: assert property (@(posedge clk) disable iff (rst)
    space_ok |-> ((DEPTH_C - count_q) >= SPACE_C)); // R9
endmodule

// File: tb/txpkt_fifo_tb.sv
module txpkt_fifo_tb;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int PORT   = 3;
  localparam int PWR    = 16;
  localparam int NVEC   = 7;

  // {wr_en, sop, eop, expect_stored, data}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 32'hA000_0000},
    {1'b1, 1'b0, 1'b1, 1'b0, 32'hA000_0001},
    {1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
    {1'b1, 1'b1, 1'b0, 1'b1, 32'hB000_0000},
    {1'b1, 1'b0, 1'b0, 1'b1, 32'hB000_0001},
    {1'b1, 1'b0, 1'b1, 1'b1, 32'hB000_0002},
    {1'b1, 1'b1, 1'b1, 1'b1, 32'hC000_0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_hold = 0, ovf_clr = 0;
  logic ctl_hold, ovf;
  logic sel_vld = 0;
  logic [ADDR_W-1:0] sel_addr = '0;
  logic wr_en = 0, wr_sop = 0, wr_eop = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic space_ok, rd_valid, rd_sop, rd_eop;
  logic rd_ready = 0;
  logic [DATA_W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [33:0] expq [NVEC];
  int nexp = 0;

  always #5 clk = ~clk;

  txpkt_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PORT_ADDR(PORT), .PWR_CYC(PWR)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_hold(cfg_hold), .ovf_clr(ovf_clr),
    .ctl_hold(ctl_hold), .ovf(ovf), .sel_vld(sel_vld), .sel_addr(sel_addr),
    .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
    .space_ok(space_ok), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_hold(input logic v);
    cfg_wr = 1; cfg_hold = v;
    step();
    cfg_wr = 0; cfg_hold = 0;
  endtask

  task automatic select_port(input logic [ADDR_W-1:0] a);
    sel_vld = 1; sel_addr = a;
    step();
    sel_vld = 0;
  endtask

  task automatic write_word(input logic s, input logic e, input logic [DATA_W-1:0] d);
    wr_en = 1; wr_sop = s; wr_eop = e; wr_data = d;
    step();
    wr_en = 0; wr_sop = 0; wr_eop = 0;
  endtask

  task automatic bring_up();
    set_hold(1'b0);
    for (int i = 0; i < PWR; i++) step();
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int got;
    step(); step();
    rst = 0;
    step();
    // R1: reset state
    chk(ctl_hold == 1'b1, "R1 hold bit after reset", 64'(ctl_hold), 1);
    chk(space_ok == 1'b0, "R1 space after reset", 64'(space_ok), 0);
    chk(rd_valid == 1'b0, "R1 valid after reset", 64'(rd_valid), 0);

    // R2: writes while held are discarded
    select_port(ADDR_W'(PORT));
    write_word(1'b1, 1'b1, 32'hDEAD_0000);
    chk(space_ok == 1'b0, "R2 space while held", 64'(space_ok), 0);

    // R3: wake interval length
    set_hold(1'b0);
    chk(space_ok == 1'b0, "R3 space at release", 64'(space_ok), 0);
    got = 0;
    for (int i = 0; i < PWR - 1; i++) begin
      step();
      if (space_ok) got++;
    end
    chk(got == 0, "R3 space during wake", 64'(got), 0);
    step();
    chk(space_ok == 1'b1, "R3 space after wake", 64'(space_ok), 1);
    chk(rd_valid == 1'b0, "R2 held write not stored", 64'(rd_valid), 0);

    // R7: selection cleared by hold; unselected write ignored
    write_word(1'b1, 1'b1, 32'hDEAD_0001);
    step(); step();
    chk(rd_valid == 1'b0, "R7 write before reselect", 64'(rd_valid), 0);

    // R6: other address deselects
    select_port(ADDR_W'(PORT));
    select_port(ADDR_W'(PORT + 1));
    write_word(1'b1, 1'b1, 32'hDEAD_0002);
    step(); step();
    chk(rd_valid == 1'b0, "R6 write after deselect", 64'(rd_valid), 0);
    select_port(ADDR_W'(PORT));

    // R4/R5: vector table walk, junk before SOP dropped
    for (int i = 0; i < NVEC; i++) begin
      wr_en = VEC[i][35]; wr_sop = VEC[i][34]; wr_eop = VEC[i][33]; wr_data = VEC[i][31:0];
      if (VEC[i][32]) begin
        expq[nexp] = {VEC[i][34], VEC[i][33], VEC[i][31:0]};
        nexp++;
      end
      step();
    end
    wr_en = 0; wr_sop = 0; wr_eop = 0;
    step();
    chk(rd_valid && rd_data == 32'hB000_0000, "R4 first stored word", 64'(rd_data), 64'hB000_0000);
    step();
    chk(rd_valid && rd_data == 32'hB000_0000 && rd_sop, "R5 stall holds word", 64'(rd_data), 64'hB000_0000);
    chk(space_ok == 1'b1, "R9 space with few words", 64'(space_ok), 1);
    rd_ready = 1;
    got = 0;
    for (int i = 0; i < 12; i++) begin
      if (rd_valid) begin
        chk(got < nexp && {rd_sop, rd_eop, rd_data} == expq[got], "R5 drain order",
            64'({rd_sop, rd_eop, rd_data}), 64'(expq[got]));
        got++;
      end
      step();
    end
    chk(got == nexp, "R4 stored count", 64'(got), 64'(nexp));
    rd_ready = 0;

    // R8: hold empties buffer
    write_word(1'b1, 1'b0, 32'h1111_0000);
    write_word(1'b0, 1'b1, 32'h1111_0001);
    step();
    chk(rd_valid == 1'b1, "R8 word pending before hold", 64'(rd_valid), 1);
    set_hold(1'b1);
    chk(rd_valid == 1'b0 && space_ok == 1'b0, "R8 empty after hold", 64'({rd_valid, space_ok}), 0);
    bring_up();
    select_port(ADDR_W'(PORT));
    write_word(1'b1, 1'b1, 32'h2222_0000);
    step();
    chk(rd_valid && rd_data == 32'h2222_0000, "R8 old words gone", 64'(rd_data), 64'h2222_0000);
    rd_ready = 1;
    step();
    rd_ready = 0;

    // R9/R10: threshold and overflow
    write_word(1'b1, 1'b0, 32'h3000_0000);
    for (int i = 1; i < 9; i++) write_word(1'b0, 1'b0, 32'h3000_0000 + i);
    chk(space_ok == 1'b1, "R9 space at threshold", 64'(space_ok), 1);
    write_word(1'b0, 1'b0, 32'h3000_0009);
    chk(space_ok == 1'b0, "R9 space below threshold", 64'(space_ok), 0);
    for (int i = 10; i < 17; i++) write_word(1'b0, 1'b0, 32'h3000_0000 + i);
    chk(ovf == 1'b0, "R10 no overflow at full", 64'(ovf), 0);
    write_word(1'b0, 1'b1, 32'h3000_0011);
    chk(ovf == 1'b1, "R10 overflow on full write", 64'(ovf), 1);
    rd_ready = 1;
    got = 0;
    for (int i = 0; i < 24; i++) begin
      if (rd_valid) begin
        chk(rd_data == 32'h3000_0000 + got, "R10 kept word order", 64'(rd_data), 64'(32'h3000_0000 + got));
        got++;
      end
      step();
    end
    chk(got == 17, "R10 dropped write", 64'(got), 17);
    rd_ready = 0;
    ovf_clr = 1;
    step();
    ovf_clr = 0;
    chk(ovf == 1'b0, "R10 overflow cleared", 64'(ovf), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule